// File: doc/BRIEF.md
# Windowed All-Ones Alarm Detector

This block watches a decoded single-rail receive bit stream and decides whether the far end is sending an all-ones alarm (AIS). A bit is taken on each clock where `bit_en` is high. The block splits the stream into fixed windows that do not overlap, counts the zeros in each window, and updates the alarm status only when a window closes. A two-bit mode input picks the rule set. The E1 dual-window rule needs two consecutive 512-bit windows to agree before the status changes. The E1 single-window rule decides on each 512-bit window by itself. The T1 rule uses one 8192-bit window with a higher zero threshold.

Every change of the alarm status is latched into an interrupt-status bit, but only while the interrupt enable is high. The latched bit stays set until software writes one to clear it through `irq_clr`. The request line is the latched bit gated by the enable.

Top module: `ais_window_monitor`

## Requirements
- R1: After reset `ais_status`, `irq_status` and `irq` are all 0.
- R2: In mode `2'b00` (E1 dual-window, 512-bit windows), `ais_status` becomes 1 at the close of a window holding 2 or fewer zeros when the window before it, in the same mode, also held 2 or fewer zeros.
- R3: In mode `2'b00`, `ais_status` becomes 0 at the close of a window holding 3 or more zeros when the window before it also held 3 or more zeros.
- R4: In mode `2'b00`, a window whose result differs from the window before it leaves `ais_status` unchanged.
- R5: In mode `2'b01` and in mode `2'b11` (E1 single-window, 512-bit windows), each window that closes sets `ais_status` to 1 if it held fewer than 3 zeros and to 0 otherwise.
- R6: In mode `2'b10` (T1, 8192-bit windows), each window that closes sets `ais_status` to 1 if it held fewer than 9 zeros and to 0 otherwise.
- R7: `ais_status` changes only on the clock edge that takes the last bit of a window. Cycles with `bit_en` low are not counted, and their `bit_in` value is ignored.
- R8: The zero count saturates and does not wrap. A window made entirely of zeros counts as holding at least the threshold.
- R9: When `ais_status` changes while `irq_en` is 1, `irq_status` becomes 1. It then holds until a cycle with `irq_clr` high clears it. A new change in that same cycle takes priority over the clear.
- R10: A change of `ais_status` while `irq_en` is 0 does not set `irq_status`. `irq` equals `irq_status` AND `irq_en`.
- R11: A change of `mode_sel` restarts the current window and discards the dual-window history, but it keeps `ais_status` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Qualifies `bit_in` for this cycle |
| bit_in | input | 1 | Decoded receive bit |
| mode_sel | input | 2 | Rule select: 00 E1 dual, 01/11 E1 single, 10 T1 |
| irq_en | input | 1 | Interrupt enable |
| irq_clr | input | 1 | Write-one-to-clear pulse for `irq_status` |
| ais_status | output | 1 | Alarm declared |
| irq_status | output | 1 | Latched alarm-change flag |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that `mode_sel` changes only while `bit_en` is low, so no received bit is dropped when a mode switch restarts the window. They also assume that `irq_clr` is a single-cycle pulse. The stimulus changes the mode and pulses the clear only in idle cycles between windows. It inserts gaps with `bit_en` low only inside windows, and it drives `bit_in` low during those gaps so that any bit counted by mistake shows up as an extra zero.

// File: rtl/ais_window_monitor.sv
module ais_window_monitor #(
  parameter int SHORT_WIN = 512,
  parameter int LONG_WIN  = 8192,
  parameter int SHORT_THR = 3,
  parameter int LONG_THR  = 9
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_en,
  input  logic       bit_in,
  input  logic [1:0] mode_sel,
  input  logic       irq_en,
  input  logic       irq_clr,
  output logic       ais_status,
  output logic       irq_status,
  output logic       irq
);

  localparam int CW  = $clog2(LONG_WIN);
  localparam int ZW  = $clog2(LONG_THR + 1);
  localparam logic [1:0] M_DUAL = 2'b00;
  localparam logic [1:0] M_LONG = 2'b10;

  logic [1:0]    mode_q;
  logic [CW-1:0] bit_cnt;
  logic [ZW-1:0] zero_cnt;
  logic          pair_vld, pair_low;
  logic          ais_next;

  wire           long_mode = (mode_q == M_LONG);
  wire           dual_mode = (mode_q == M_DUAL);
  wire [CW-1:0]  last_idx  = long_mode ? CW'(LONG_WIN - 1) : CW'(SHORT_WIN - 1);
  wire [ZW-1:0]  thr       = long_mode ? ZW'(LONG_THR) : ZW'(SHORT_THR);
  wire           mode_chg  = (mode_sel != mode_q);
  wire           take      = bit_en && !mode_chg;
  wire           win_end   = take && (bit_cnt == last_idx);
  wire [ZW-1:0]  zero_next = (!bit_in && zero_cnt != ZW'(LONG_THR)) ? zero_cnt + 1'b1 : zero_cnt;
  wire           win_low   = (zero_next < thr);

  always_comb begin
    ais_next = ais_status;
    if (win_end) begin
      if (!dual_mode) ais_next = win_low;
      else if (pair_vld && pair_low == win_low) ais_next = win_low;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= M_DUAL;
      bit_cnt  <= '0;
      zero_cnt <= '0;
      pair_vld <= 1'b0;
      pair_low <= 1'b0;
    end else if (mode_chg) begin
      mode_q   <= mode_sel;
      bit_cnt  <= '0;
      zero_cnt <= '0;
      pair_vld <= 1'b0;
    end else if (win_end) begin
      bit_cnt  <= '0;
      zero_cnt <= '0;
      pair_vld <= 1'b1;
      pair_low <= win_low;
    end else if (take) begin
      bit_cnt  <= bit_cnt + 1'b1;
      zero_cnt <= zero_next;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ais_status <= 1'b0;
      irq_status <= 1'b0;
    end else begin
      ais_status <= ais_next;
      if (ais_next != ais_status && irq_en) irq_status <= 1'b1;
      else if (irq_clr)                     irq_status <= 1'b0;
    end
  end

  assign irq = irq_status & irq_en;

  AST_ZERO_SAT: assert property (@(posedge clk) disable iff (!rst_n) zero_cnt <= ZW'(LONG_THR)); // R8
  AST_WIN_BOUND: assert property (@(posedge clk) disable iff (!rst_n) bit_cnt <= last_idx); // R7
  AST_STATUS_AT_EDGE: assert property (@(posedge clk) disable iff (!rst_n) !win_end |=> $stable(ais_status)); // R7
  AST_MODE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n) mode_chg |=> $stable(ais_status)); // R11
  AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n) ($rose(ais_status) && $past(irq_en)) |-> irq_status); // R9
  AST_IRQ_FALL: assert property (@(posedge clk) disable iff (!rst_n) ($fell(ais_status) && $past(irq_en)) |-> irq_status); // R9
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (irq_status && !irq_clr) |=> irq_status); // R9
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n) (!irq_en && !irq_status) |=> !irq_status); // R10

endmodule

// File: tb/tb_ais_window_monitor.sv
module tb_ais_window_monitor;
  logic clk = 1'b0, rst_n = 1'b0, bit_en = 1'b0, bit_in = 1'b1;
  logic [1:0] mode_sel = 2'b00;
  logic irq_en = 1'b0, irq_clr = 1'b0;
  logic ais_status, irq_status, irq;

  int checks = 0, failures = 0;
  bit exp_ais = 0, exp_irq = 0, pv = 0, pl = 0;

  ais_window_monitor dut (.*);

  always #2 clk = ~clk;

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_bits(int n, int z, bit gaps);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (gaps && (i % 7) == 3) begin
        bit_en = 1'b0; bit_in = 1'b0;
        @(negedge clk);
      end
      bit_en = 1'b1;
      bit_in = (i < z) ? 1'b0 : 1'b1;
    end
    @(negedge clk);
    bit_en = 1'b0; bit_in = 1'b1;
  endtask

  task automatic model_close(int z);
    int thr;
    bit low, prev;
    thr  = (mode_sel == 2'b10) ? 9 : 3;
    low  = (z < thr);
    prev = exp_ais;
    if (mode_sel != 2'b00) exp_ais = low;
    else begin
      if (pv && pl == low) exp_ais = low;
      pv = 1; pl = low;
    end
    if (exp_ais != prev && irq_en) exp_irq = 1;
  endtask

  task automatic window(int z, bit gaps, string req);
    int len;
    len = (mode_sel == 2'b10) ? 8192 : 512;
    send_bits(len, z, gaps);
    model_close(z);
    check(ais_status == exp_ais, req, ais_status, exp_ais);
    check(irq_status == exp_irq, {req, "/R9 irq_status"}, irq_status, exp_irq);
    check(irq == (exp_irq & irq_en), {req, "/R10 irq"}, irq, exp_irq & irq_en);
  endtask

  task automatic clear_irq();
    @(negedge clk); irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
    exp_irq = 0;
    check(irq_status == 1'b0, "R9 w1c", irq_status, 0);
  endtask

  task automatic set_mode(logic [1:0] m);
    @(negedge clk); mode_sel = m; pv = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(ais_status == 1'b0, "R1 ais", ais_status, 0);
    check(irq_status == 1'b0, "R1 irq_status", irq_status, 0);
    check(irq == 1'b0, "R1 irq", irq, 0);
    rst_n = 1'b1;
    irq_en = 1'b1;

    set_mode(2'b01);
    for (int z = 0; z <= 6; z++) begin
      window(z, 0, "R5 single");
      if (exp_irq) begin
        repeat (3) @(negedge clk);
        check(irq_status == 1'b1, "R9 hold", irq_status, 1);
        clear_irq();
      end
    end
    set_mode(2'b11);
    window(5, 0, "R5 alias");
    window(1, 0, "R5 alias");
    clear_irq();
    window(4, 0, "R5 alias");
    clear_irq();

    set_mode(2'b01);
    send_bits(300, 0, 1);
    check(ais_status == exp_ais, "R7 midwindow", ais_status, exp_ais);
    send_bits(212, 0, 1);
    model_close(0);
    check(ais_status == exp_ais, "R7 gaps ignored", ais_status, exp_ais);
    clear_irq();

    send_bits(300, 300, 0);
    set_mode(2'b00);
    check(ais_status == 1'b1, "R11 status kept", ais_status, 1);
    window(5, 0, "R11 history dropped");
    window(5, 0, "R11 pair after restart");
    clear_irq();

    for (int a = 0; a <= 4; a++)
      for (int b = 0; b <= 4; b++) begin
        window(a, 0, "R2/R3/R4 dual");
        window(b, 0, "R2/R3/R4 dual");
        if (exp_irq) clear_irq();
      end

    irq_en = 1'b0;
    window(exp_ais ? 4 : 0, 0, "R10 disabled");
    window(exp_ais ? 4 : 0, 0, "R10 disabled");
    check(irq_status == 1'b0, "R10 no latch", irq_status, 0);
    irq_en = 1'b1;
    window(exp_ais ? 4 : 0, 0, "R10 enabled");
    window(exp_ais ? 4 : 0, 0, "R10 enabled");
    check(irq == 1'b1, "R10 irq up", irq, 1);
    @(negedge clk); irq_en = 1'b0;
    @(negedge clk);
    check(irq == 1'b0, "R10 irq gated", irq, 0);
    check(irq_status == 1'b1, "R10 status held", irq_status, 1);
    irq_en = 1'b1;
    clear_irq();

    set_mode(2'b10);
    window(8, 0, "R6 long");
    window(9, 0, "R6 long");
    window(0, 0, "R6 long");
    window(8192, 0, "R8 saturate");
    window(7, 0, "R6 long");
    window(10, 0, "R6 long");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule